// File: doc/BRIEF.md
# Serial Character Transmitter with Byte Buffer

This block turns bytes written by a host into asynchronous serial frames on a single output line. Each accepted byte waits in a buffer until the shift stage is free. The shift stage then sends a low start bit, the data bits starting with the least significant one, an optional parity bit and one or two high stop bits. Every bit lasts a fixed number of pulses of an external baud tick. The pulse count is 16 in the normal setting and 8 in the fast setting.

The buffer works in one of two ways. In queued mode it holds up to `DEPTH` bytes in arrival order. In single mode it holds one byte, which acts as a plain holding register. The block has two status outputs. One reports that the buffer is empty. The other reports that the buffer is empty and the line is idle as well. A buffer-drained event can raise an interrupt, which is gated by an enable input. The interrupt clears when the host writes again or acknowledges it.

Configuration inputs are sampled when a byte enters the shift stage, so each frame keeps the format it started with. When the last stop bit ends and another byte is waiting, the next start bit follows at once, with no idle gap between the frames.

Top module: `ser_tx_path`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1, `shift_empty` is 1 and `irq` is 0.
- R2: A frame is one start bit at 0, then the data bits least significant first, then stop bits at 1. The data bit count is 5 + `cfg_data_len` (00=5, 01=6, 10=7, 11=8).
- R3: When `cfg_par_en` is 1, one parity bit follows the data bits. `cfg_par_mode` 00 makes the count of ones among the data and parity bits odd, 01 makes that count even, 10 sends a constant 1 and 11 sends a constant 0.
- R4: When `cfg_two_stop` is 1, two stop bits are sent, and `shift_empty` stays 0 during the second one. Otherwise one stop bit is sent.
- R5: One bit lasts 16 `baud_tick` pulses when `cfg_half_rate` is 0, and 8 pulses when it is 1. `txd` changes only at a bit boundary or when a frame is loaded.
- R6: In queued mode (`cfg_fifo_en`=1) the buffer holds `DEPTH` bytes and sends them in write order. A write to a full buffer is dropped.
- R7: In single mode (`cfg_fifo_en`=0) the buffer holds one byte, and a further write is dropped while it is occupied. `hold_empty` is 1 in the cycle after the byte moves into the shift stage.
- R8: `shift_empty` is 1 only when the buffer is empty and the last stop bit has ended. It is 0 while any frame bit is being sent.
- R9: In queued mode `hold_empty` is 0 while any byte waits in the buffer.
- R10: An internal flag sets when the last buffered byte moves into the shift stage. `irq` equals that flag ANDed with `cfg_irq_en`. A write (`wr_en`) or a pulse on `irq_ack` clears the flag one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle oversampling pulse |
| cfg_fifo_en | input | 1 | 1 = queued mode, 0 = single mode |
| cfg_half_rate | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| cfg_data_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_mode | input | 2 | Parity kind: odd, even, force 1, force 0 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DW | Byte to send |
| irq_ack | input | 1 | Interrupt status read, clears the flag |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Buffer empty |
| shift_empty | output | 1 | Buffer empty and line idle |
| irq | output | 1 | Transmit-empty interrupt |

## Verification
Wrong internal state shows up on `txd` within one bit time, as a shifted, missing or extra data bit, as a wrong parity value, or as a stop bit of the wrong length. The bench decodes each frame at mid-bit points, so an error in the tick count or the shift order changes the decoded byte of that same frame. Wrong buffer pointer or count state shows up only after draining, as a byte sent out of order or as a frame too many or too few. For that reason the overflow and single-mode cases count every frame until `shift_empty` returns. Interrupt flag errors show up on `irq` one cycle after the load, write or acknowledge that should have changed it.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } tx_state_e;

   typedef enum logic [1:0] {
      PAR_ODD  = 2'b00,
      PAR_EVEN = 2'b01,
      PAR_ONE  = 2'b10,
      PAR_ZERO = 2'b11
   } par_mode_e;

   typedef struct packed {
      logic [1:0] len;
      logic       par_en;
      par_mode_e  par_mode;
      logic       two_stop;
      logic       half_rate;
   } frame_cfg_t;

   localparam int DATA_MIN = 5;

   function automatic logic calc_parity(input logic [7:0] d,
                                        input logic [1:0] len,
                                        input par_mode_e  mode);
      logic p;
      p = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (i < DATA_MIN + int'(len)) p = p ^ d[i];
      end
      case (mode)
         PAR_ODD:  return ~p;
         PAR_EVEN: return p;
         PAR_ONE:  return 1'b1;
         default:  return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/ser_tx_buf.sv
module ser_tx_buf #(
   parameter int DW    = 8,
   parameter int DEPTH = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         fifo_en,
   input  logic                         push,
   input  logic [DW-1:0]                push_data,
   input  logic                         pop,
   output logic [DW-1:0]                pop_data,
   output logic                         empty,
   output logic                         full,
   output logic [$clog2(DEPTH+1)-1:0]   level
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
   localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ser_tx_buf: DEPTH must be at least 2");
      end
      if (DW < 1) begin : g_bad_width
         $error("ser_tx_buf: DW must be positive");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          do_push, do_pop;

   assign empty    = (level == '0);
   assign full     = fifo_en ? (level == DEPTH_C) : !empty;
   assign do_pop   = pop && !empty;
   assign do_push  = push && (!full || do_pop);
   assign pop_data = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= DEPTH_C); // R6
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (level == $past(level))); // R6

endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
   import ser_tx_pkg::*;
#(
   parameter int DW    = 8,
   parameter int OS_HI = 16,
   parameter int OS_LO = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          baud_tick,
   input  frame_cfg_t    cfg,
   input  logic          src_valid,
   input  logic [DW-1:0] src_data,
   output logic          take,
   output logic          txd,
   output logic          busy
);
   localparam int CW = $clog2(OS_HI);
   localparam int LW = $clog2(DW);

   generate
      if (DW != 8) begin : g_bad_width
         $error("ser_tx_shift: DW must be 8");
      end
      if (OS_LO < 2 || OS_LO >= OS_HI) begin : g_bad_os
         $error("ser_tx_shift: need 2 <= OS_LO < OS_HI");
      end
   endgenerate

   tx_state_e     state;
   frame_cfg_t    cfg_q;
   logic [DW-1:0] shreg;
   logic [CW-1:0] tick_cnt, last_tick;
   logic [LW-1:0] bit_cnt, last_bit;
   logic          stop_cnt, par_bit;
   logic          bit_end, last_stop;

   assign last_tick = cfg_q.half_rate ? CW'(OS_LO - 1) : CW'(OS_HI - 1);
   assign last_bit  = LW'(DATA_MIN - 1) + LW'(cfg_q.len);
   assign bit_end   = baud_tick && (tick_cnt == last_tick);
   assign last_stop = (state == ST_STOP) && bit_end &&
                      (!cfg_q.two_stop || stop_cnt);
   assign busy      = (state != ST_IDLE);
   assign take      = src_valid && ((state == ST_IDLE) || last_stop);

   always_comb begin
      case (state)
         ST_START: txd = 1'b0;
         ST_DATA:  txd = shreg[0];
         ST_PAR:   txd = par_bit;
         default:  txd = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cfg_q    <= '0;
         shreg    <= '0;
         tick_cnt <= '0;
         bit_cnt  <= '0;
         stop_cnt <= 1'b0;
         par_bit  <= 1'b0;
      end else if (take) begin
         state    <= ST_START;
         cfg_q    <= cfg;
         shreg    <= src_data;
         tick_cnt <= '0;
         bit_cnt  <= '0;
         stop_cnt <= 1'b0;
         par_bit  <= calc_parity(src_data, cfg.len, cfg.par_mode);
      end else if (busy && baud_tick) begin
         if (!bit_end) begin
            tick_cnt <= tick_cnt + 1'b1;
         end else begin
            tick_cnt <= '0;
            case (state)
               ST_START: state <= ST_DATA;
               ST_DATA: begin
                  shreg <= shreg >> 1;
                  if (bit_cnt == last_bit) begin
                     state <= cfg_q.par_en ? ST_PAR : ST_STOP;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               ST_PAR: state <= ST_STOP;
               ST_STOP: begin
                  if (last_stop) state <= ST_IDLE;
                  else           stop_cnt <= 1'b1;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !txd); // R2
   AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !baud_tick) |=> $stable(txd)); // R5

endmodule

// File: rtl/ser_tx_path.sv
module ser_tx_path
   import ser_tx_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   parameter int OS_HI = 16,
   parameter int OS_LO = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          baud_tick,
   input  logic          cfg_fifo_en,
   input  logic          cfg_half_rate,
   input  logic [1:0]    cfg_data_len,
   input  logic          cfg_par_en,
   input  logic [1:0]    cfg_par_mode,
   input  logic          cfg_two_stop,
   input  logic          cfg_irq_en,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          irq_ack,
   output logic          txd,
   output logic          hold_empty,
   output logic          shift_empty,
   output logic          irq
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] ONE_C = CW'(1);

   frame_cfg_t    cfg;
   logic          buf_empty, buf_full, take, busy, drained, irq_pend;
   logic [DW-1:0] head;
   logic [CW-1:0] level;

   assign cfg.len       = cfg_data_len;
   assign cfg.par_en    = cfg_par_en;
   assign cfg.par_mode  = par_mode_e'(cfg_par_mode);
   assign cfg.two_stop  = cfg_two_stop;
   assign cfg.half_rate = cfg_half_rate;

   ser_tx_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_en   (cfg_fifo_en),
      .push      (wr_en),
      .push_data (wr_data),
      .pop       (take),
      .pop_data  (head),
      .empty     (buf_empty),
      .full      (buf_full),
      .level     (level)
   );

   ser_tx_shift #(.DW(DW), .OS_HI(OS_HI), .OS_LO(OS_LO)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .cfg       (cfg),
      .src_valid (!buf_empty),
      .src_data  (head),
      .take      (take),
      .txd       (txd),
      .busy      (busy)
   );

   assign drained = take && !wr_en && (level == ONE_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                irq_pend <= 1'b0;
      else if (drained)          irq_pend <= 1'b1;
      else if (wr_en || irq_ack) irq_pend <= 1'b0;
   end

   assign hold_empty  = buf_empty;
   assign shift_empty = buf_empty && !busy;
   assign irq         = irq_pend && cfg_irq_en;

   AST_WRITE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !irq); // R10
   AST_SINGLE_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_fifo_en && take && !wr_en && level == ONE_C) |=> hold_empty); // R7
   AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      shift_empty |-> txd); // R8
   AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full |-> !hold_empty); // R9

endmodule

// File: tb/tb_ser_tx_path.sv
module tb_ser_tx_path;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       cfg_fifo_en = 1'b1, cfg_half_rate = 1'b0;
   logic [1:0] cfg_data_len = 2'b11, cfg_par_mode = 2'b00;
   logic       cfg_par_en = 1'b0, cfg_two_stop = 1'b0, cfg_irq_en = 1'b0;
   logic       wr_en = 1'b0, irq_ack = 1'b0;
   logic [7:0] wr_data = '0;
   logic       txd, hold_empty, shift_empty, irq;

   int n_checks = 0, n_fail = 0;
   bit tick_on = 1'b0;
   int tick_div = 1, tick_ph = 0;

   always #5 clk = ~clk;

   ser_tx_path dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .cfg_fifo_en(cfg_fifo_en), .cfg_half_rate(cfg_half_rate),
      .cfg_data_len(cfg_data_len), .cfg_par_en(cfg_par_en),
      .cfg_par_mode(cfg_par_mode), .cfg_two_stop(cfg_two_stop),
      .cfg_irq_en(cfg_irq_en), .wr_en(wr_en), .wr_data(wr_data),
      .irq_ack(irq_ack), .txd(txd), .hold_empty(hold_empty),
      .shift_empty(shift_empty), .irq(irq)
   );

   always @(negedge clk) begin
      if (tick_on) begin
         baud_tick <= (tick_ph == 0);
         tick_ph = (tick_ph + 1) % tick_div;
      end else begin
         baud_tick <= 1'b0;
         tick_ph = 0;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int bit_len();
      return (cfg_half_rate ? 8 : 16) * tick_div;
   endfunction

   function automatic bit exp_par(input int d, input int nb, input int mode);
      int ones = 0;
      for (int i = 0; i < nb; i++) ones += (d >> i) & 1;
      case (mode)
         0: return (ones % 2) == 0;
         1: return (ones % 2) == 1;
         2: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic write(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // started=1: the start bit is already on the line and ticks were just enabled
   task automatic rx_frame(input int exp_data, input bit started);
      int bl = bit_len();
      int nb = 5 + int'(cfg_data_len);
      int got = 0;
      if (!started) while (txd !== 1'b0) @(negedge clk);
      repeat (bl / 2) @(negedge clk);
      check(txd == 1'b0, "R2 start bit", txd, 0);
      for (int i = 0; i < nb; i++) begin
         repeat (bl) @(negedge clk);
         got |= int'(txd) << i;
      end
      check(got == exp_data, "R2 data bits", got, exp_data);
      if (cfg_par_en) begin
         repeat (bl) @(negedge clk);
         check(txd == exp_par(exp_data, nb, cfg_par_mode), "R3 parity bit",
               txd, exp_par(exp_data, nb, cfg_par_mode));
      end
      repeat (bl) @(negedge clk);
      check(txd == 1'b1, "R2 stop bit", txd, 1);
      if (cfg_two_stop) begin
         repeat (bl) @(negedge clk);
         check(txd == 1'b1 && shift_empty == 1'b0, "R4 second stop bit",
               {txd, shift_empty}, 2'b10);
      end
   endtask

   task automatic wait_quiet(input string req);
      repeat (bit_len() + 4) @(negedge clk);
      check(shift_empty == 1'b1 && hold_empty == 1'b1 && txd == 1'b1, req,
            {shift_empty, hold_empty, txd}, 3'b111);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check({txd, hold_empty, shift_empty, irq} == 4'b1110, "R1 reset state",
            {txd, hold_empty, shift_empty, irq}, 4'b1110);
   endtask

   task automatic t_basic();
      cfg_fifo_en = 1; cfg_half_rate = 0; cfg_data_len = 2'b11;
      cfg_par_en = 0; cfg_two_stop = 0; tick_div = 2; tick_on = 1;
      write(8'hA5);
      @(negedge clk);
      check(shift_empty == 1'b0 && hold_empty == 1'b1, "R8 busy during frame",
            {shift_empty, hold_empty}, 2'b01);
      rx_frame(8'hA5, 0);   // R5 at 16 ticks per bit
      wait_quiet("R8 empty after stop");
   endtask

   task automatic t_formats();
      tick_div = 1; cfg_half_rate = 0;
      cfg_data_len = 2'b00; cfg_par_en = 1; cfg_par_mode = 2'b01; cfg_two_stop = 0;
      write(8'h13); rx_frame(8'h13, 0); wait_quiet("R3 even 5 bits");
      cfg_data_len = 2'b10; cfg_par_mode = 2'b00; cfg_two_stop = 1;
      write(8'h5B); rx_frame(8'h5B, 0); wait_quiet("R4 two stops idle");
      cfg_data_len = 2'b01; cfg_par_mode = 2'b10; cfg_two_stop = 0;
      write(8'h2A); rx_frame(8'h2A, 0); wait_quiet("R3 force one");
      cfg_data_len = 2'b11; cfg_par_mode = 2'b11;
      write(8'hFF); rx_frame(8'hFF, 0); wait_quiet("R3 force zero");
      cfg_par_en = 0;
   endtask

   task automatic t_half_rate();
      cfg_half_rate = 1; tick_div = 1; cfg_data_len = 2'b11;
      write(8'h6C); rx_frame(8'h6C, 0);   // R5 at 8 ticks per bit
      wait_quiet("R5 fast rate end");
   endtask

   task automatic t_fifo_fill();
      tick_on = 0; cfg_fifo_en = 1; cfg_half_rate = 1; tick_div = 1;
      @(negedge clk);
      for (int i = 0; i < 66; i++) write(8'(i));
      check(hold_empty == 1'b0, "R9 buffer holds bytes", hold_empty, 0);
      tick_on = 1;
      for (int i = 0; i < 65; i++) rx_frame(i, i == 0);   // R6 order, 66th dropped
      repeat (2 * bit_len()) @(negedge clk);
      check(shift_empty == 1'b1 && txd == 1'b1, "R6 no extra frame",
            {shift_empty, txd}, 2'b11);
   endtask

   task automatic t_single();
      tick_on = 0; cfg_fifo_en = 0; cfg_half_rate = 1;
      @(negedge clk);
      write(8'h11);
      @(negedge clk);
      check(hold_empty == 1'b1, "R7 empty after load", hold_empty, 1);
      write(8'h22);
      check(hold_empty == 1'b0, "R7 holding occupied", hold_empty, 0);
      write(8'h33);
      tick_on = 1;
      rx_frame(8'h11, 1);
      rx_frame(8'h22, 0);
      repeat (2 * bit_len()) @(negedge clk);
      check(shift_empty == 1'b1 && txd == 1'b1, "R7 third write dropped",
            {shift_empty, txd}, 2'b11);
      cfg_fifo_en = 1;
   endtask

   task automatic t_irq();
      tick_on = 0; cfg_irq_en = 1; cfg_half_rate = 1;
      @(negedge clk);
      write(8'hA0);
      @(negedge clk);
      check(irq == 1'b1, "R10 set on drain", irq, 1);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      @(negedge clk);
      check(irq == 1'b0, "R10 cleared by ack", irq, 0);
      write(8'hB1);
      @(negedge clk);
      check(irq == 1'b0 && hold_empty == 1'b0, "R10 no set while queued",
            {irq, hold_empty}, 2'b00);
      cfg_irq_en = 0;
      tick_on = 1;
      rx_frame(8'hA0, 1);
      rx_frame(8'hB1, 0);
      check(irq == 1'b0, "R10 gated by enable", irq, 0);
      cfg_irq_en = 1;
      @(negedge clk);
      check(irq == 1'b1, "R10 pending shows on enable", irq, 1);
      write(8'hC2);
      check(irq == 1'b0, "R10 cleared by write", irq, 0);
      rx_frame(8'hC2, 0);
      wait_quiet("R8 empty after irq test");
   endtask

   initial begin
      t_reset();
      t_basic();
      t_formats();
      t_half_rate();
      t_fifo_fill();
      t_single();
      t_irq();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule